// File: doc/BRIEF.md
# Retimer Channel Override Control

This block is the per-channel control stage of a serial retimer. It sits between the
configuration register fields and the channel datapath, and it turns register values
plus live status into the enables and selects that the datapath uses. Two static
force bits act on the detected-signal flag, and through it on the channel enable. A
level-held channel reset bit keeps the channel disabled. Each datapath control has its
own override-enable bit. When that bit is set, the register value replaces the value
from automatic control.

The output data source is picked by a 3-bit code. The code is decoded into a one-hot
steering vector for the output multiplexer. Codes that have no defined meaning steer
to mute, so undefined data never reaches the line. Every output is registered once.
The datapath therefore sees glitch-free controls, exactly one clock after a register
field or status input changes.

Top module: `retimer_chan_ovr_ctrl`

## Requirements
- R1: With `force_sd_on`=1, `force_sd_off`=0 and `chan_rst`=0, the next cycle has `sig_det_eff`=1 and `chan_en`=1, whatever `sig_det_raw` is.
- R2: With `force_sd_off`=1, the next cycle has `sig_det_eff`=0 and `chan_en`=0. This holds whatever `force_sd_on` and `sig_det_raw` are, so forcing off wins over forcing on.
- R3: With both force bits at 0, `sig_det_eff` equals `sig_det_raw` one cycle later. `chan_en` equals it too, unless the channel reset is held.
- R4: While `chan_rst`=1, the next cycle has `chan_rst_hold`=1 and `chan_en`=0. The bit is a level and does not clear itself: both stay that way for as long as it is held. One cycle after it drops, `chan_rst_hold`=0.
- R5: `src_onehot` bit 0 means raw data, bit 1 retimed data, bit 2 pattern generator and bit 3 mute. The selected code maps 3'b000 to raw, 3'b001 to retimed, 3'b100 to pattern and 3'b111 to mute, and every other code maps to mute. Exactly one bit is set.
- R6: The selected code is `src_sel_cfg` when `src_ovr_en`=1 and `src_sel_auto` otherwise. `src_onehot` reflects it one cycle later.
- R7: `cp_en_eff` equals `cp_en_cfg` when `cp_ovr_en`=1 and `cp_en_auto` otherwise, one cycle later. Bit 1 is the phase-detector pump and bit 0 the frequency-detector pump; 1 means enabled.
- R8: `lpf_dac_eff` equals `lpf_dac_cfg` when `lpf_ovr_en`=1 and `lpf_dac_auto` otherwise, one cycle later.
- R9: `fld_en_eff` equals `fld_en_cfg` when `fld_ovr_en`=1 and `fld_en_auto` otherwise, one cycle later.
- R10: During synchronous reset (`rst_n`=0 at a clock edge) the outputs become `sig_det_eff`=0, `chan_en`=0, `chan_rst_hold`=1, `src_onehot`=4'b1000, `cp_en_eff`=0, `lpf_dac_eff`=0 and `fld_en_eff`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_sd_on | input | 1 | Static force of signal detect high |
| force_sd_off | input | 1 | Static force of signal detect low (priority) |
| chan_rst | input | 1 | Level-held channel reset bit |
| sig_det_raw | input | 1 | Live signal-detect flag |
| src_ovr_en | input | 1 | Output source override enable |
| src_sel_cfg | input | 3 | Register output source code |
| src_sel_auto | input | 3 | Automatic output source code |
| cp_ovr_en | input | 1 | Charge-pump override enable |
| cp_en_cfg | input | CP_W | Register pump enables |
| cp_en_auto | input | CP_W | Automatic pump enables |
| lpf_ovr_en | input | 1 | Loop-filter DAC override enable |
| lpf_dac_cfg | input | LPF_W | Register loop-filter DAC value |
| lpf_dac_auto | input | LPF_W | Automatic loop-filter DAC value |
| fld_ovr_en | input | 1 | False-lock-detect override enable |
| fld_en_cfg | input | 1 | Register false-lock-detect enable |
| fld_en_auto | input | 1 | Automatic false-lock-detect enable |
| sig_det_eff | output | 1 | Effective signal detect |
| chan_en | output | 1 | Effective channel enable |
| chan_rst_hold | output | 1 | Channel held in reset |
| src_onehot | output | 4 | One-hot output source steering |
| cp_en_eff | output | CP_W | Effective pump enables |
| lpf_dac_eff | output | LPF_W | Effective loop-filter DAC value |
| fld_en_eff | output | 1 | Effective false-lock-detect enable |

## Verification
Every result is due exactly one clock after its stimulus, since one register stands between each input and each output. The bench drives new inputs on a falling edge. It then lets one rising edge pass and compares on the following falling edge, so each comparison sees the result of the values it applied. Because the next stimulus goes on only after that comparison, settings that hold a level, such as the channel reset bit, are observed over several consecutive cycles.

// File: rtl/retimer_chan_ovr_pkg.sv
// Shared widths and codes for the retimer channel override control.
// Assumes the output source select is a 3-bit code with four defined values.
package retimer_chan_ovr_pkg;
    localparam int SRC_SEL_W = 3;
    localparam int N_SRC     = 4;

    localparam logic [SRC_SEL_W-1:0] CODE_RAW     = 3'b000;
    localparam logic [SRC_SEL_W-1:0] CODE_RETIMED = 3'b001;
    localparam logic [SRC_SEL_W-1:0] CODE_PATTERN = 3'b100;
    localparam logic [SRC_SEL_W-1:0] CODE_MUTE    = 3'b111;

    // Bit positions within the one-hot steering vector.
    typedef enum logic [1:0] {
        SRC_RAW     = 2'd0,
        SRC_RETIMED = 2'd1,
        SRC_PATTERN = 2'd2,
        SRC_MUTE    = 2'd3
    } src_kind_e;
endpackage

// File: rtl/retimer_chan_force.sv
// Combines the live signal-detect flag with the two static force bits and the
// channel reset level. Assumes forcing off outranks forcing on.
module retimer_chan_force (
    input  logic force_on,
    input  logic force_off,
    input  logic rst_level,
    input  logic sd_live,
    output logic sd_eff,
    output logic en_eff
);
    // Resolve effective signal detect, then qualify it with the channel reset.
    always_comb begin
        if (force_off)     sd_eff = 1'b0;
        else if (force_on) sd_eff = 1'b1;
        else               sd_eff = sd_live;
        en_eff = sd_eff & ~rst_level;
    end
endmodule

// File: rtl/retimer_ovr_gate.sv
// Per-field override gate: passes the register value when the override enable
// is set, else the automatic value. Assumes both values share width W.
module retimer_ovr_gate #(
    parameter int W = 1
) (
    input  logic         ovr_en,
    input  logic [W-1:0] cfg_val,
    input  logic [W-1:0] auto_val,
    output logic [W-1:0] eff_val
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // Select one bit of the effective value.
            assign eff_val[gi] = ovr_en ? cfg_val[gi] : auto_val[gi];
        end
    endgenerate
endmodule

// File: rtl/retimer_src_decode.sv
// Decodes the output source code into one-hot steering. Assumes undefined codes
// must steer to mute so no undefined data reaches the output.
module retimer_src_decode
    import retimer_chan_ovr_pkg::*;
(
    input  logic [SRC_SEL_W-1:0] code,
    output logic [N_SRC-1:0]     onehot
);
    // Map each defined code to its steering bit; anything else is mute.
    always_comb begin
        onehot = '0;
        unique case (code)
            CODE_RAW:     onehot[SRC_RAW]     = 1'b1;
            CODE_RETIMED: onehot[SRC_RETIMED] = 1'b1;
            CODE_PATTERN: onehot[SRC_PATTERN] = 1'b1;
            default:      onehot[SRC_MUTE]    = 1'b1;
        endcase
    end
endmodule

// File: rtl/retimer_chan_ovr_ctrl.sv
// Per-channel override control for a serial retimer. Resolves the force bits
// and the channel reset into an enable, gates each datapath control behind its
// override enable, decodes the output source, and registers all results once.
// Assumes register fields are static between writes; the reset is synchronous.
module retimer_chan_ovr_ctrl
    import retimer_chan_ovr_pkg::*;
#(
    parameter int CP_W  = 2,
    parameter int LPF_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 force_sd_on,
    input  logic                 force_sd_off,
    input  logic                 chan_rst,
    input  logic                 sig_det_raw,
    input  logic                 src_ovr_en,
    input  logic [SRC_SEL_W-1:0] src_sel_cfg,
    input  logic [SRC_SEL_W-1:0] src_sel_auto,
    input  logic                 cp_ovr_en,
    input  logic [CP_W-1:0]      cp_en_cfg,
    input  logic [CP_W-1:0]      cp_en_auto,
    input  logic                 lpf_ovr_en,
    input  logic [LPF_W-1:0]     lpf_dac_cfg,
    input  logic [LPF_W-1:0]     lpf_dac_auto,
    input  logic                 fld_ovr_en,
    input  logic                 fld_en_cfg,
    input  logic                 fld_en_auto,
    output logic                 sig_det_eff,
    output logic                 chan_en,
    output logic                 chan_rst_hold,
    output logic [N_SRC-1:0]     src_onehot,
    output logic [CP_W-1:0]      cp_en_eff,
    output logic [LPF_W-1:0]     lpf_dac_eff,
    output logic                 fld_en_eff
);
    localparam logic [N_SRC-1:0] ONEHOT_MUTE = N_SRC'(1) << SRC_MUTE;

    logic                 sd_nxt, en_nxt;
    logic [SRC_SEL_W-1:0] code_nxt;
    logic [N_SRC-1:0]     onehot_nxt;
    logic [CP_W-1:0]      cp_nxt;
    logic [LPF_W-1:0]     lpf_nxt;
    logic                 fld_nxt;

    retimer_chan_force u_force (
        .force_on  (force_sd_on),
        .force_off (force_sd_off),
        .rst_level (chan_rst),
        .sd_live   (sig_det_raw),
        .sd_eff    (sd_nxt),
        .en_eff    (en_nxt)
    );

    retimer_ovr_gate #(.W(SRC_SEL_W)) u_src_gate (
        .ovr_en (src_ovr_en), .cfg_val (src_sel_cfg),
        .auto_val (src_sel_auto), .eff_val (code_nxt)
    );

    retimer_src_decode u_src_dec (
        .code   (code_nxt),
        .onehot (onehot_nxt)
    );

    retimer_ovr_gate #(.W(CP_W)) u_cp_gate (
        .ovr_en (cp_ovr_en), .cfg_val (cp_en_cfg),
        .auto_val (cp_en_auto), .eff_val (cp_nxt)
    );

    retimer_ovr_gate #(.W(LPF_W)) u_lpf_gate (
        .ovr_en (lpf_ovr_en), .cfg_val (lpf_dac_cfg),
        .auto_val (lpf_dac_auto), .eff_val (lpf_nxt)
    );

    retimer_ovr_gate #(.W(1)) u_fld_gate (
        .ovr_en (fld_ovr_en), .cfg_val (fld_en_cfg),
        .auto_val (fld_en_auto), .eff_val (fld_nxt)
    );

    // Register every control so the datapath sees one clean update per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_det_eff   <= 1'b0;
            chan_en       <= 1'b0;
            chan_rst_hold <= 1'b1;
            src_onehot    <= ONEHOT_MUTE;
            cp_en_eff     <= '0;
            lpf_dac_eff   <= '0;
            fld_en_eff    <= 1'b0;
        end else begin
            sig_det_eff   <= sd_nxt;
            chan_en       <= en_nxt;
            chan_rst_hold <= chan_rst;
            src_onehot    <= onehot_nxt;
            cp_en_eff     <= cp_nxt;
            lpf_dac_eff   <= lpf_nxt;
            fld_en_eff    <= fld_nxt;
        end
    end
endmodule

// File: rtl/retimer_chan_ovr_ctrl_chk.sv
// Checker for the retimer channel override control, bound to the top module.
// Relates registered outputs to the inputs of the previous cycle.
module retimer_chan_ovr_ctrl_chk #(
    parameter int CP_W  = 2,
    parameter int LPF_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_sd_on,
    input logic             force_sd_off,
    input logic             chan_rst,
    input logic             sig_det_raw,
    input logic             cp_ovr_en,
    input logic [CP_W-1:0]  cp_en_cfg,
    input logic             lpf_ovr_en,
    input logic [LPF_W-1:0] lpf_dac_cfg,
    input logic             fld_ovr_en,
    input logic             fld_en_cfg,
    input logic             sig_det_eff,
    input logic             chan_en,
    input logic             chan_rst_hold,
    input logic [3:0]       src_onehot,
    input logic [CP_W-1:0]  cp_en_eff,
    input logic [LPF_W-1:0] lpf_dac_eff,
    input logic             fld_en_eff
);
    assert_force_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (force_sd_on && !force_sd_off && !chan_rst) |=> (sig_det_eff && chan_en));

    assert_force_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        force_sd_off |=> (!sig_det_eff && !chan_en));

    assert_follow_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_sd_on && !force_sd_off) |=> (sig_det_eff == $past(sig_det_raw)));

    assert_chan_rst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (chan_rst_hold && !chan_en));

    assert_src_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_onehot) == 1);

    assert_cp_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cp_ovr_en |=> (cp_en_eff == $past(cp_en_cfg)));

    assert_lpf_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lpf_ovr_en |=> (lpf_dac_eff == $past(lpf_dac_cfg)));

    assert_fld_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fld_ovr_en |=> (fld_en_eff == $past(fld_en_cfg)));
endmodule

bind retimer_chan_ovr_ctrl retimer_chan_ovr_ctrl_chk #(.CP_W(CP_W), .LPF_W(LPF_W)) u_chk (
    .clk (clk), .rst_n (rst_n),
    .force_sd_on (force_sd_on), .force_sd_off (force_sd_off),
    .chan_rst (chan_rst), .sig_det_raw (sig_det_raw),
    .cp_ovr_en (cp_ovr_en), .cp_en_cfg (cp_en_cfg),
    .lpf_ovr_en (lpf_ovr_en), .lpf_dac_cfg (lpf_dac_cfg),
    .fld_ovr_en (fld_ovr_en), .fld_en_cfg (fld_en_cfg),
    .sig_det_eff (sig_det_eff), .chan_en (chan_en),
    .chan_rst_hold (chan_rst_hold), .src_onehot (src_onehot),
    .cp_en_eff (cp_en_eff), .lpf_dac_eff (lpf_dac_eff),
    .fld_en_eff (fld_en_eff)
);

// File: tb/retimer_chan_ovr_ctrl_bench.sv
`timescale 1ns/1ps
// Sweeps every combination of the small control fields and compares the
// registered outputs one clock after each stimulus against computed values.
module retimer_chan_ovr_ctrl_bench;
    localparam int CP_W  = 2;
    localparam int LPF_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic force_sd_on = 0, force_sd_off = 0, chan_rst = 0, sig_det_raw = 0;
    logic src_ovr_en = 0;
    logic [2:0] src_sel_cfg = 0, src_sel_auto = 0;
    logic cp_ovr_en = 0;
    logic [CP_W-1:0] cp_en_cfg = 0, cp_en_auto = 0;
    logic lpf_ovr_en = 0;
    logic [LPF_W-1:0] lpf_dac_cfg = 0, lpf_dac_auto = 0;
    logic fld_ovr_en = 0, fld_en_cfg = 0, fld_en_auto = 0;
    logic sig_det_eff, chan_en, chan_rst_hold, fld_en_eff;
    logic [3:0] src_onehot;
    logic [CP_W-1:0] cp_en_eff;
    logic [LPF_W-1:0] lpf_dac_eff;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    retimer_chan_ovr_ctrl #(.CP_W(CP_W), .LPF_W(LPF_W)) u_retimer_chan_ovr_ctrl (
        .clk (clk), .rst_n (rst_n),
        .force_sd_on (force_sd_on), .force_sd_off (force_sd_off),
        .chan_rst (chan_rst), .sig_det_raw (sig_det_raw),
        .src_ovr_en (src_ovr_en), .src_sel_cfg (src_sel_cfg), .src_sel_auto (src_sel_auto),
        .cp_ovr_en (cp_ovr_en), .cp_en_cfg (cp_en_cfg), .cp_en_auto (cp_en_auto),
        .lpf_ovr_en (lpf_ovr_en), .lpf_dac_cfg (lpf_dac_cfg), .lpf_dac_auto (lpf_dac_auto),
        .fld_ovr_en (fld_ovr_en), .fld_en_cfg (fld_en_cfg), .fld_en_auto (fld_en_auto),
        .sig_det_eff (sig_det_eff), .chan_en (chan_en), .chan_rst_hold (chan_rst_hold),
        .src_onehot (src_onehot), .cp_en_eff (cp_en_eff),
        .lpf_dac_eff (lpf_dac_eff), .fld_en_eff (fld_en_eff)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_onehot(input logic [2:0] c);
        case (c)
            3'b000:  return 4'b0001;
            3'b001:  return 4'b0010;
            3'b100:  return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    // Let the result of the values just applied reach the outputs.
    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10: reset state
        cmp("R10 sig_det_eff", sig_det_eff, 0);
        cmp("R10 chan_en", chan_en, 0);
        cmp("R10 chan_rst_hold", chan_rst_hold, 1);
        cmp("R10 src_onehot", src_onehot, 4'b1000);
        cmp("R10 cp_en_eff", cp_en_eff, 0);
        cmp("R10 lpf_dac_eff", lpf_dac_eff, 0);
        cmp("R10 fld_en_eff", fld_en_eff, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: every combination of force, reset and live detect
        for (int v = 0; v < 16; v++) begin
            logic esd, een;
            {force_sd_on, force_sd_off, chan_rst, sig_det_raw} = 4'(v);
            settle();
            esd = force_sd_off ? 1'b0 : (force_sd_on ? 1'b1 : sig_det_raw);
            een = esd & ~chan_rst;
            if (force_sd_off)      cmp("R2 sig_det_eff", sig_det_eff, esd);
            else if (force_sd_on)  cmp("R1 sig_det_eff", sig_det_eff, esd);
            else                   cmp("R3 sig_det_eff", sig_det_eff, esd);
            cmp(chan_rst ? "R4 chan_en" : "R1 R2 R3 chan_en", chan_en, een);
            cmp("R4 chan_rst_hold", chan_rst_hold, chan_rst);
        end

        // R4: level-held reset stays in force over many cycles, then releases
        force_sd_on = 1; force_sd_off = 0; chan_rst = 1;
        for (int k = 0; k < 5; k++) begin
            settle();
            cmp("R4 held chan_en", chan_en, 0);
            cmp("R4 held chan_rst_hold", chan_rst_hold, 1);
        end
        chan_rst = 0;
        settle();
        cmp("R4 released chan_rst_hold", chan_rst_hold, 0);
        cmp("R4 released chan_en", chan_en, 1);
        force_sd_on = 0;

        // R5 R6: every source code through both override paths
        for (int v = 0; v < 128; v++) begin
            {src_ovr_en, src_sel_cfg, src_sel_auto} = 7'(v);
            settle();
            cmp(src_ovr_en ? "R5 R6 src_onehot ovr" : "R5 R6 src_onehot auto",
                src_onehot, exp_onehot(src_ovr_en ? src_sel_cfg : src_sel_auto));
        end

        // R7: pump enables
        for (int v = 0; v < 32; v++) begin
            {cp_ovr_en, cp_en_cfg, cp_en_auto} = 5'(v);
            settle();
            cmp("R7 cp_en_eff", cp_en_eff, cp_ovr_en ? cp_en_cfg : cp_en_auto);
        end

        // R8: loop-filter DAC, every register value against two automatic values
        for (int v = 0; v < 128; v++) begin
            lpf_ovr_en   = v[6];
            lpf_dac_cfg  = 5'(v);
            lpf_dac_auto = v[5] ? 5'(31 - v[4:0]) : 5'(v * 7);
            settle();
            cmp("R8 lpf_dac_eff", lpf_dac_eff, lpf_ovr_en ? lpf_dac_cfg : lpf_dac_auto);
        end

        // R9: false-lock-detect enable
        for (int v = 0; v < 8; v++) begin
            {fld_ovr_en, fld_en_cfg, fld_en_auto} = 3'(v);
            settle();
            cmp("R9 fld_en_eff", fld_en_eff, fld_ovr_en ? fld_en_cfg : fld_en_auto);
        end

        // R10: reset applied mid-run returns the reset state
        cp_ovr_en = 1; cp_en_cfg = 2'b11; chan_rst = 0;
        rst_n = 0;
        settle();
        cmp("R10 rerun chan_rst_hold", chan_rst_hold, 1);
        cmp("R10 rerun cp_en_eff", cp_en_eff, 0);
        cmp("R10 rerun src_onehot", src_onehot, 4'b1000);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule